// File: doc/BRIEF.md
# Dual Timer/Counter Unit

This block holds two independent 16-bit counting units. Each unit is stored as a low byte and a high byte. Each unit advances either once per machine-cycle strobe or once per falling edge seen on its own count pin. A shared configuration byte chooses, for each unit, one of four counting modes, the counting source and pin gating. A control byte holds the run bits and the two overflow flags. Software reaches every byte through a small synchronous read/write port.

An overflow sets the unit's flag. Interrupt vectoring logic clears that flag with a one-cycle acknowledge strobe. Each unit also gives a one-cycle overflow pulse that a baud-rate generator can use. In the split mode, unit 0 becomes two 8-bit counters. Its high half borrows unit 1's run bit and flag. While this is so, unit 1 keeps counting and still pulses, but it no longer sets a flag.

Top module: `twin_timer`

## Requirements
- R1: After a synchronous reset, all six registers read 0, both flags are low and both pulses are low.
- R2: The register addresses are fixed. Address 0 is the configuration byte: unit 0 in bits [3:0] and unit 1 in bits [7:4]. In each nibble, bits [1:0] are the mode, bit 2 selects pin counting and bit 3 is the gate enable. Address 1 is the control byte: bit0 is run0, bit1 is run1, bit2 is flag0 and bit3 is flag1. Addresses 2 and 3 are the low and high bytes of unit 0. Addresses 4 and 5 are the low and high bytes of unit 1. Read data appears one clock after the address. A byte write in the same cycle as an increment takes the written value.
- R3: In timer source, an enabled unit advances by exactly one per clock that has `tick` high. With `tick` low and no write, no count changes.
- R4: In pin source, the pin passes through a two-stage synchroniser and is sampled on each tick. The unit advances once when one sample is high and the next is low. It never advances on two consecutive ticks.
- R5: Mode 00 forms a 13-bit counter from the high byte and the low 5 bits of the low byte. Bits [7:5] of the low byte are kept unchanged. Counting past 1FFFh gives 0000h and an overflow.
- R6: Mode 01 is a 16-bit counter. Counting past FFFFh gives 0000h and an overflow.
- R7: Mode 10 counts the low byte only. When the low byte passes FFh, it is loaded from the high byte and an overflow occurs. The high byte never changes.
- R8: Mode 11 on unit 0 splits it in two. The low byte is an 8-bit counter that uses unit 0's run bit, source, gate and flag. The high byte advances on every tick while run1 is set and sets flag1 when it wraps.
- R9: While unit 0 is in mode 11, unit 1 counts without needing run1. Its overflows still pulse `ovf_pulse[1]`, but they do not set flag1.
- R10: Unit 1 in mode 11 holds both of its bytes.
- R11: With the gate bit set, a unit counts only while its run bit is set and its synchronised gate pin is high.
- R12: An overflow sets the unit's flag. `ack_clr[i]` clears flag i. A control-byte write loads both flags. A hardware set in the same cycle as a clear or write wins.
- R13: Each overflow of unit 0, and each overflow of unit 1's own counter, gives a one-cycle pulse on `ovf_pulse`. The pulse appears in the same cycle as the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle strobe |
| cnt_pin | input | 2 | External count inputs, one per unit |
| gate_pin | input | 2 | External gate inputs, one per unit |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| ack_clr | input | 2 | Flag clear strobes from vectoring logic |
| ovf_flag | output | 2 | Overflow flags |
| ovf_pulse | output | 2 | One-cycle overflow pulses |

## Verification
The bench starts counts just below each wrap point.
- A design with a wrong carry would miss the 1FFFh and FFFFh wraps, or it would corrupt the kept upper low-byte bits in mode 00.
- Reload values of FFh force an overflow on every tick. A reload design that also touched the high byte would give a wrong count.

Split mode is checked with run1 both low and high. An error in borrowing the controls would show up as one of three faults: the high byte counting without run1, unit 1 stalling, or unit 1 setting flag1.

The bench also checks that an acknowledge in the overflow cycle leaves the flag set. It checks that a closed gate freezes the count. It checks that slow pin edges are each counted exactly once.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  localparam int BYTE_W     = 8;
  localparam int PRESCALE_W = 5;
  localparam int N_UNITS    = 2;
  localparam int ADDR_W     = 3;
  localparam int CFG_BITS   = 4;

  typedef enum logic [1:0] {
    MODE_PRESCALED = 2'b00,
    MODE_WIDE      = 2'b01,
    MODE_RELOAD    = 2'b10,
    MODE_SPLIT     = 2'b11
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   use_pin;
    tmode_e mode;
  } unit_cfg_t;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam int                BYTE_BASE = 2;
endpackage

// File: rtl/tt_pin_sampler.sv
module tt_pin_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cnt_pin,
  input  logic gate_pin,
  output logic gate_level,
  output logic cnt_fall
);
  logic [SYNC_STAGES-1:0] cnt_sync;
  logic [SYNC_STAGES-1:0] gate_sync;
  logic                   cnt_samp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_sync  <= '0;
      gate_sync <= '0;
      cnt_samp  <= 1'b0;
    end else begin
      cnt_sync  <= {cnt_sync[SYNC_STAGES-2:0], cnt_pin};
      gate_sync <= {gate_sync[SYNC_STAGES-2:0], gate_pin};
      if (tick) cnt_samp <= cnt_sync[SYNC_STAGES-1];
    end
  end

  assign gate_level = gate_sync[SYNC_STAGES-1];
  // previous tick sample high, present sample low
  assign cnt_fall   = tick & cnt_samp & ~cnt_sync[SYNC_STAGES-1];
endmodule

// File: rtl/tt_count_unit.sv
module tt_count_unit
  import twin_timer_pkg::*;
#(
  parameter int W        = BYTE_W,
  parameter int PRE      = PRESCALE_W,
  parameter bit SPLIT_EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  tmode_e       mode,
  input  logic         en_main,
  input  logic         en_aux,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi,
  output logic         ovf_main,
  output logic         ovf_aux
);
  logic [W-1:0]     lo_n, hi_n;
  logic [W+PRE-1:0] v13;
  logic [2*W-1:0]   v16;

  always_comb begin
    lo_n     = lo;
    hi_n     = hi;
    ovf_main = 1'b0;
    ovf_aux  = 1'b0;
    v13      = {hi, lo[PRE-1:0]} + (W+PRE)'(1);
    v16      = {hi, lo} + (2*W)'(1);
    case (mode)
      MODE_PRESCALED: if (en_main) begin
        hi_n           = v13[W+PRE-1:PRE];
        lo_n[PRE-1:0]  = v13[PRE-1:0];
        ovf_main       = &{hi, lo[PRE-1:0]};
      end
      MODE_WIDE: if (en_main) begin
        {hi_n, lo_n} = v16;
        ovf_main     = &{hi, lo};
      end
      MODE_RELOAD: if (en_main) begin
        if (&lo) begin
          lo_n     = hi;
          ovf_main = 1'b1;
        end else begin
          lo_n = lo + W'(1);
        end
      end
      default: if (SPLIT_EN) begin
        if (en_main) begin
          lo_n     = lo + W'(1);
          ovf_main = &lo;
        end
        if (en_aux) begin
          hi_n    = hi + W'(1);
          ovf_aux = &hi;
        end
      end
    endcase
    if (wr_lo) lo_n = wr_data;
    if (wr_hi) hi_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= lo_n;
      hi <= hi_n;
    end
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        gate_pin,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [1:0]        ack_clr,
  output logic [1:0]        ovf_flag,
  output logic [1:0]        ovf_pulse
);
  unit_cfg_t [N_UNITS-1:0]              cfg_q;
  logic      [N_UNITS-1:0]              run_q;
  logic      [N_UNITS-1:0][BYTE_W-1:0]  cnt_lo, cnt_hi;
  logic      [N_UNITS-1:0]              gate_lvl, cnt_fall, gate_ok, src_ev;
  logic      [N_UNITS-1:0]              en_main, en_aux, ovf_main, ovf_aux;
  logic      [N_UNITS-1:0]              set_ev;
  logic                                 split0, ctrl_wr;
  logic      [BYTE_W-1:0]               rd_mux;

  assign split0  = (cfg_q[0].mode == MODE_SPLIT);
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BYTE_BASE + 2*i);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BYTE_BASE + 2*i + 1);

    tt_pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk(clk), .rst(rst), .tick(tick),
      .cnt_pin(cnt_pin[i]), .gate_pin(gate_pin[i]),
      .gate_level(gate_lvl[i]), .cnt_fall(cnt_fall[i])
    );

    assign gate_ok[i] = ~cfg_q[i].gate | gate_lvl[i];
    assign src_ev[i]  = cfg_q[i].use_pin ? cnt_fall[i] : tick;

    tt_count_unit #(.W(BYTE_W), .PRE(PRESCALE_W), .SPLIT_EN(i == 0)) u_cnt (
      .clk(clk), .rst(rst), .mode(cfg_q[i].mode),
      .en_main(en_main[i]), .en_aux(en_aux[i]),
      .wr_lo(wr_en && wr_addr == LO_A), .wr_hi(wr_en && wr_addr == HI_A),
      .wr_data(wr_data), .lo(cnt_lo[i]), .hi(cnt_hi[i]),
      .ovf_main(ovf_main[i]), .ovf_aux(ovf_aux[i])
    );
  end

  // unit 1 loses its run bit to unit 0's high half while unit 0 is split
  assign en_main[0] = run_q[0] & gate_ok[0] & src_ev[0];
  assign en_main[1] = (run_q[1] | split0) & gate_ok[1] & src_ev[1];
  assign en_aux     = {1'b0, tick & run_q[1]};

  assign set_ev[0] = ovf_main[0];
  assign set_ev[1] = split0 ? ovf_aux[0] : (ovf_main[1] | ovf_aux[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      run_q     <= '0;
      ovf_flag  <= '0;
      ovf_pulse <= '0;
    end else begin
      if (wr_en && wr_addr == A_CFG) cfg_q <= wr_data;
      if (ctrl_wr) run_q <= wr_data[1:0];
      for (int i = 0; i < N_UNITS; i++) begin
        if (set_ev[i])       ovf_flag[i] <= 1'b1;
        else if (ctrl_wr)    ovf_flag[i] <= wr_data[2+i];
        else if (ack_clr[i]) ovf_flag[i] <= 1'b0;
      end
      ovf_pulse <= ovf_main;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == A_CFG)  rd_mux = cfg_q;
    if (rd_addr == A_CTRL) rd_mux = {4'b0, ovf_flag, run_q};
    for (int i = 0; i < N_UNITS; i++) begin
      if (rd_addr == ADDR_W'(BYTE_BASE + 2*i))     rd_mux = cnt_lo[i];
      if (rd_addr == ADDR_W'(BYTE_BASE + 2*i + 1)) rd_mux = cnt_hi[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
  import twin_timer_pkg::*;
(
  input logic                             clk,
  input logic                             rst,
  input logic                             tick,
  input logic                             wr_en,
  input logic [ADDR_W-1:0]                wr_addr,
  input logic [1:0]                       ack_clr,
  input logic [1:0]                       ovf_flag,
  input logic [1:0]                       ovf_pulse,
  input logic [N_UNITS*CFG_BITS-1:0]      cfg,
  input logic [N_UNITS-1:0][BYTE_W-1:0]   cnt_lo,
  input logic [N_UNITS-1:0][BYTE_W-1:0]   cnt_hi,
  input logic [N_UNITS-1:0]               set_ev,
  input logic [N_UNITS-1:0]               en_main
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (ovf_flag == 2'b00 && ovf_pulse == 2'b00));

  assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  assert_pin_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    (en_main[0] && cfg[2] && !wr_en) |=> !en_main[0]);

  assert_unit1_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg[5:4] == 2'b11 && !wr_en) |=> ($stable(cnt_lo[1]) && $stable(cnt_hi[1])));

  assert_ack_clears0_R12: assert property (@(posedge clk) disable iff (rst)
    (ack_clr[0] && !set_ev[0] && !(wr_en && wr_addr == A_CTRL)) |=> !ovf_flag[0]);

  assert_ack_clears1_R12: assert property (@(posedge clk) disable iff (rst)
    (ack_clr[1] && !set_ev[1] && !(wr_en && wr_addr == A_CTRL)) |=> !ovf_flag[1]);

  assert_set_wins_R12: assert property (@(posedge clk) disable iff (rst)
    set_ev[1] |=> ovf_flag[1]);

  assert_pulse_with_flag_R13: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse[0] |-> ovf_flag[0]);
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
  .ack_clr(ack_clr), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse),
  .cfg(cfg_q), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .set_ev(set_ev),
  .en_main(en_main)
);

// File: tb/test_twin_timer.sv
`timescale 1ns/1ps
module test_twin_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] cnt_pin = 2'b00, gate_pin = 2'b00;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] ack_clr = 2'b00;
  logic [1:0] ovf_flag, ovf_pulse;

  int n_checks = 0, n_err = 0;
  int pc0 = 0, pc1 = 0;
  bit done = 0;

  always #4 clk = ~clk;

  twin_timer i_twin_timer (
    .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .ack_clr(ack_clr), .ovf_flag(ovf_flag), .ovf_pulse(ovf_pulse)
  );

  always @(negedge clk) if (!rst) begin
    if (ovf_pulse[0]) pc0++;
    if (ovf_pulse[1]) pc1++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setup(input logic [7:0] cfg, input logic [7:0] ctrl,
                       input logic [7:0] l0, input logic [7:0] h0,
                       input logic [7:0] l1, input logic [7:0] h1);
    wr(3'd0, cfg); wr(3'd2, l0); wr(3'd3, h0); wr(3'd4, l1); wr(3'd5, h1);
    wr(3'd1, ctrl);
  endtask

  function automatic logic [15:0] f_pre(input logic [7:0] lo, input logic [7:0] hi,
                                        input int n, output int wraps);
    logic [13:0] v;
    v = {1'b0, hi, lo[4:0]} + 14'(n);
    wraps = int'(v[13]);
    return {v[12:5], lo[7:5], v[4:0]};
  endfunction

  function automatic logic [16:0] f_wide(input logic [15:0] s, input int n);
    return {1'b0, s} + 17'(n);
  endfunction

  function automatic logic [7:0] f_reload(input logic [7:0] lo, input logic [7:0] hi,
                                          input int n, output int wraps);
    logic [7:0] v = lo;
    wraps = 0;
    for (int k = 0; k < n; k++) begin
      if (v == 8'hFF) begin v = hi; wraps++; end
      else v = v + 8'd1;
    end
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, l, h, l1, h1;
    logic [16:0] w;
    logic [15:0] e;
    int n, wraps, p0, p1, seed;
    seed = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), b); chk("R1 reg after reset", b, 8'h00);
    end
    chk("R1 flags after reset", ovf_flag, 2'b00);
    chk("R1 pulses after reset", ovf_pulse, 2'b00);

    // R2 map readback
    setup(8'hA5, 8'h03, 8'h11, 8'h22, 8'h33, 8'h44);
    rd(3'd0, b); chk("R2 cfg readback", b, 8'hA5);
    rd(3'd1, b); chk("R2 ctrl readback", b, 8'h03);
    rd(3'd5, b); chk("R2 unit1 high readback", b, 8'h44);

    // R6 random 16-bit
    for (int it = 0; it < 6; it++) begin
      h = ($urandom % 2) ? 8'hFF : 8'($urandom); l = 8'($urandom);
      n = 1 + int'($urandom % 600);
      setup(8'h01, 8'h01, l, h, 8'h00, 8'h00);
      p0 = pc0; ticks(n); w = f_wide({h, l}, n);
      rd(3'd2, l1); rd(3'd3, h1);
      chk("R6 16-bit count", {h1, l1}, w[15:0]);
      chk("R6 flag on wrap", ovf_flag[0], w[16]);
      chk("R13 pulse count", pc0 - p0, int'(w[16]));
    end

    // R5 random 13-bit
    for (int it = 0; it < 6; it++) begin
      h = ($urandom % 2) ? 8'hFF : 8'($urandom); l = 8'($urandom);
      n = 1 + int'($urandom % 600);
      setup(8'h00, 8'h01, l, h, 8'h00, 8'h00);
      p0 = pc0; ticks(n); e = f_pre(l, h, n, wraps);
      rd(3'd2, l1); rd(3'd3, h1);
      chk("R5 13-bit count", {h1, l1}, e);
      chk("R5 flag on wrap", ovf_flag[0], wraps > 0);
      chk("R13 pulse count mode00", pc0 - p0, wraps);
    end

    // R7 random reload, including reload value FFh
    for (int it = 0; it < 6; it++) begin
      h = (it < 2) ? 8'hFF : 8'($urandom); l = 8'($urandom);
      n = 1 + int'($urandom % 600);
      setup(8'h02, 8'h01, l, h, 8'h00, 8'h00);
      p0 = pc0; ticks(n); b = f_reload(l, h, n, wraps);
      rd(3'd2, l1); rd(3'd3, h1);
      chk("R7 reload low byte", l1, b);
      chk("R7 high byte untouched", h1, h);
      chk("R13 pulse count reload", pc0 - p0, wraps);
    end

    // R3 no tick -> no change
    setup(8'h01, 8'h01, 8'h40, 8'h00, 8'h00, 8'h00);
    repeat (10) @(negedge clk);
    rd(3'd2, b); chk("R3 no count without tick", b, 8'h40);

    // R8/R9 split with run1 low
    setup(8'h13, 8'h01, 8'hF0, 8'h00, 8'hF0, 8'hFF);
    p0 = pc0; p1 = pc1; ticks(32);
    rd(3'd2, b); chk("R8 split low byte", b, 8'h10);
    rd(3'd3, b); chk("R8 split high idle w/o run1", b, 8'h00);
    rd(3'd4, l1); rd(3'd5, h1);
    chk("R9 unit1 counts without run1", {h1, l1}, 16'h0010);
    chk("R9 unit1 pulse", pc1 - p1, 1);
    chk("R9 flag1 not set by unit1", ovf_flag[1], 1'b0);
    chk("R8 flag0 from low byte", ovf_flag[0], 1'b1);
    // R8 high half with run1
    wr(3'd3, 8'hF8); wr(3'd1, 8'h03);
    p1 = pc1; ticks(16);
    rd(3'd3, b); chk("R8 split high counts", b, 8'h08);
    chk("R8 flag1 from high byte", ovf_flag[1], 1'b1);
    chk("R13 no unit1 pulse from high half", pc1 - p1, 0);

    // R10 unit1 mode 11 holds
    setup(8'h31, 8'h03, 8'h00, 8'h00, 8'h5A, 8'hC3);
    ticks(50);
    rd(3'd4, l1); rd(3'd5, h1); rd(3'd2, b);
    chk("R10 unit1 held", {h1, l1}, 16'hC35A);
    chk("R10 unit0 still counts", b, 8'd50);

    // R11 gate
    setup(8'h09, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
    ticks(20);
    rd(3'd2, b); chk("R11 gate low blocks", b, 8'h00);
    gate_pin[0] = 1'b1; repeat (3) @(negedge clk);
    ticks(20);
    rd(3'd2, b); chk("R11 gate high runs", b, 8'd20);
    gate_pin[0] = 1'b0;

    // R4 pin counting
    setup(8'h05, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00);
    @(negedge clk); tick = 1'b1;
    repeat (6) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      cnt_pin[0] = 1'b1; repeat (4) @(negedge clk);
      cnt_pin[0] = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk); tick = 1'b0;
    rd(3'd2, b); chk("R4 one count per falling edge", b, 8'd5);

    // R12 set wins over ack in the same cycle
    setup(8'h01, 8'h01, 8'hFF, 8'hFF, 8'h00, 8'h00);
    @(negedge clk); tick = 1'b1; ack_clr = 2'b01;
    @(negedge clk); tick = 1'b0; ack_clr = 2'b00;
    chk("R12 set beats ack", ovf_flag[0], 1'b1);
    @(negedge clk); ack_clr = 2'b01;
    @(negedge clk); ack_clr = 2'b00;
    chk("R12 ack clears", ovf_flag[0], 1'b0);
    wr(3'd1, 8'h0C);
    chk("R12 software flag write", ovf_flag, 2'b11);
    rd(3'd1, b); chk("R2 ctrl shows flags", b, 8'h0C);

    // R2 write beats increment
    setup(8'h01, 8'h01, 8'h10, 8'h22, 8'h00, 8'h00);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h55;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd(3'd2, b); chk("R2 write wins low", b, 8'h55);
    rd(3'd3, b); chk("R2 high unchanged", b, 8'h22);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule